// File: doc/BRIEF.md
# Dual-Port GPIO with Pull-ups

This block holds two 16-pin general-purpose ports, A and B, and is reached through a simple register write/read bus. Each port has a 32-bit control word and a 16-bit data word. Within the control word every pin owns two adjacent bits, one for its output enable and one for its pull-up. The level visible on a pin is resolved from three contributors. The first is the CPU data word gated by the CPU output enable. The second is an external peripheral's drive, gated by its own enable. The third is the pull-up, which counts only when neither side drives the pin. The peripheral drive inputs are registered on every clock.

Every accepted write to a port's control or data register compares that port's line levels before and after the update. Up to four listeners can be attached. Each has an enable, a port-A trigger mask and a port-B trigger mask. When the masks that belong to the written port overlap the set of changed lines, the listener receives a one-cycle pulse together with a snapshot of both ports. A small two-state machine produces these pulses. In `NS_IDLE` no pulse is shown. The transition IDLE->PULSE fires on a write with at least one hit. PULSE->PULSE fires when another hitting write follows at once. PULSE->IDLE fires otherwise. In `NS_PULSE` the registered hit vector is presented. Two sticky flags report writes of the wrong size and any attempt to enable port interrupts.

Top module: `gpio2_top`

## Requirements
- R1: Pin n of a port takes its output enable from control bit 2n and its pull-up enable from control bit 2n+1.
- R2: Each pin level is (cpu_oe AND cpu_data) OR (per_oe AND per_do) OR (NOT(cpu_oe OR per_oe) AND pull-up), and it drives pin_a/pin_b.
- R3: A read is combinational. Address 0 returns port A control and address 1 returns port B control. Address 2 returns the resolved port A pins and address 3 the resolved port B pins, not the stored data. Address 4 returns the interrupt-control word. Any other address returns 0.
- R4: A write to a port's control (address 0/1) or data (address 2/3) register computes the change set as old line XOR new line for that port only, using the same sampled peripheral drive for both. An empty change set gives no notification, and a later pin change caused only by the peripheral gives none either.
- R5: Listener l (0..3) with lsn_en[l]=1 is notified when the written port's mask (bits 16l+15:16l of lsn_mask_a or lsn_mask_b) meets the change set. The ntf_pulse[l] is high for the one cycle after the write edge, and ntf_pin_a/ntf_pin_b show both ports' post-write levels.
- R6: Writing a nonzero value to the interrupt-control register (address 4, 16-bit) sets err_irqctl, which stays set until reset. Writing zero leaves it unchanged.
- R7: Control registers take only 32-bit writes (bus_wide=1). Data and interrupt-control registers take only 16-bit writes (bus_wide=0). A wrong-size write sets the sticky err_size and changes no register. Writes to addresses 5..7 are ignored.
- R8: After reset every control, data and interrupt-control register is zero, so every pin, read and pulse output is 0.
- R9: The peripheral drive inputs reach the pins one clock after they are applied.
- R10: Back-to-back hitting writes give a pulse in each following cycle, and the state machine returns to idle after the first cycle with no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| per_oe_a | input | 16 | Peripheral output enable, port A |
| per_do_a | input | 16 | Peripheral drive value, port A |
| per_oe_b | input | 16 | Peripheral output enable, port B |
| per_do_b | input | 16 | Peripheral drive value, port B |
| lsn_en | input | 4 | Listener enables |
| lsn_mask_a | input | 64 | Port A trigger masks, 16 bits per listener |
| lsn_mask_b | input | 64 | Port B trigger masks, 16 bits per listener |
| pin_a | output | 16 | Resolved port A levels |
| pin_b | output | 16 | Resolved port B levels |
| ntf_pulse | output | 4 | One-cycle notification per listener |
| ntf_pin_a | output | 16 | Port A levels captured with the notification |
| ntf_pin_b | output | 16 | Port B levels captured with the notification |
| err_size | output | 1 | Sticky wrong-size write flag |
| err_irqctl | output | 1 | Sticky nonzero interrupt-control write flag |

## Verification
The peripheral sampler and the write-triggered change detector can act in the same clock. A peripheral enable or value can change in the very cycle a CPU write lands. The bench provokes this on purpose and also lets it happen under random traffic. Its reference model then decides that only the CPU-caused difference may raise a pulse, and that the pins still move one cycle later when the peripheral value takes effect. A second overlap, a new hitting write arriving while a pulse is showing, is provoked with back-to-back writes and judged against the hits of the second write.

// File: rtl/gpio2_pkg.sv
package gpio2_pkg;

    typedef enum logic [2:0] {
        RA_CTL_A = 3'd0,
        RA_CTL_B = 3'd1,
        RA_DAT_A = 3'd2,
        RA_DAT_B = 3'd3,
        RA_IRQ   = 3'd4
    } reg_addr_e;

    typedef enum logic {
        NS_IDLE  = 1'b0,
        NS_PULSE = 1'b1
    } ntf_state_e;

endpackage

// File: rtl/gpio2_port.sv
module gpio2_port #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ctl_we,
    input  logic           dat_we,
    input  logic [2*W-1:0] wr_ctl,
    input  logic [W-1:0]   wr_dat,
    input  logic [W-1:0]   per_oe_q,
    input  logic [W-1:0]   per_do_q,
    output logic [2*W-1:0] ctl_q,
    output logic [W-1:0]   line,
    output logic [W-1:0]   line_next
);

    logic [W-1:0]   dat_q;
    logic [2*W-1:0] ctl_n;
    logic [W-1:0]   dat_n;
    logic [W-1:0]   oe_cur, pu_cur, oe_nxt, pu_nxt;

    assign ctl_n = ctl_we ? wr_ctl : ctl_q;
    assign dat_n = dat_we ? wr_dat : dat_q;

    for (genvar p = 0; p < W; p++) begin : g_split
        assign oe_cur[p] = ctl_q[2*p];
        assign pu_cur[p] = ctl_q[2*p+1];
        assign oe_nxt[p] = ctl_n[2*p];
        assign pu_nxt[p] = ctl_n[2*p+1];
    end

    assign line      = (oe_cur & dat_q) | (per_oe_q & per_do_q)
                     | (~(oe_cur | per_oe_q) & pu_cur);
    assign line_next = (oe_nxt & dat_n) | (per_oe_q & per_do_q)
                     | (~(oe_nxt | per_oe_q) & pu_nxt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            dat_q <= '0;
        end else begin
            ctl_q <= ctl_n;
            dat_q <= dat_n;
        end
    end

endmodule

// File: rtl/gpio2_notify.sv
module gpio2_notify
    import gpio2_pkg::*;
#(
    parameter int W  = 16,
    parameter int NL = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_a,
    input  logic          trig_b,
    input  logic [W-1:0]  chg_a,
    input  logic [W-1:0]  chg_b,
    input  logic [NL-1:0] lsn_en,
    input  logic [NL*W-1:0] mask_a,
    input  logic [NL*W-1:0] mask_b,
    input  logic [W-1:0]  snap_a,
    input  logic [W-1:0]  snap_b,
    output logic [NL-1:0] pulse,
    output logic [W-1:0]  snap_a_q,
    output logic [W-1:0]  snap_b_q
);

    ntf_state_e    st_q, st_d;
    logic [NL-1:0] hit, hit_q;
    logic          any_hit;

    for (genvar l = 0; l < NL; l++) begin : g_lsn
        assign hit[l] = lsn_en[l]
                      & ((trig_a & (|(mask_a[l*W +: W] & chg_a)))
                       | (trig_b & (|(mask_b[l*W +: W] & chg_b))));
    end

    assign any_hit = |hit;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            NS_IDLE:  st_d = any_hit ? NS_PULSE : NS_IDLE;
            NS_PULSE: st_d = any_hit ? NS_PULSE : NS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= NS_IDLE;
            hit_q    <= '0;
            snap_a_q <= '0;
            snap_b_q <= '0;
        end else begin
            st_q  <= st_d;
            hit_q <= hit;
            if (any_hit) begin
                snap_a_q <= snap_a;
                snap_b_q <= snap_b;
            end
        end
    end

    always_comb begin
        unique case (st_q)
            NS_IDLE:  pulse = '0;
            NS_PULSE: pulse = hit_q;
        endcase
    end

endmodule

// File: rtl/gpio2_top.sv
module gpio2_top
    import gpio2_pkg::*;
#(
    parameter int W  = 16,
    parameter int NL = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [2:0]      bus_addr,
    input  logic            bus_wide,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic [W-1:0]    per_oe_a,
    input  logic [W-1:0]    per_do_a,
    input  logic [W-1:0]    per_oe_b,
    input  logic [W-1:0]    per_do_b,
    input  logic [NL-1:0]   lsn_en,
    input  logic [NL*W-1:0] lsn_mask_a,
    input  logic [NL*W-1:0] lsn_mask_b,
    output logic [W-1:0]    pin_a,
    output logic [W-1:0]    pin_b,
    output logic [NL-1:0]   ntf_pulse,
    output logic [W-1:0]    ntf_pin_a,
    output logic [W-1:0]    ntf_pin_b,
    output logic            err_size,
    output logic            err_irqctl
);

    localparam int CW = 2 * W;

    logic [W-1:0]  pa_oe_q, pa_do_q, pb_oe_q, pb_do_q;
    logic          we_ctl_a, we_ctl_b, we_dat_a, we_dat_b, we_irq;
    logic          size_bad;
    logic [15:0]   irq_q;
    logic [CW-1:0] ctl_a_q, ctl_b_q;
    logic [W-1:0]  nxt_a, nxt_b;

    always_comb begin
        we_ctl_a = 1'b0;
        we_ctl_b = 1'b0;
        we_dat_a = 1'b0;
        we_dat_b = 1'b0;
        we_irq   = 1'b0;
        size_bad = 1'b0;
        if (bus_wr) begin
            case (bus_addr)
                RA_CTL_A: if (bus_wide)  we_ctl_a = 1'b1; else size_bad = 1'b1;
                RA_CTL_B: if (bus_wide)  we_ctl_b = 1'b1; else size_bad = 1'b1;
                RA_DAT_A: if (!bus_wide) we_dat_a = 1'b1; else size_bad = 1'b1;
                RA_DAT_B: if (!bus_wide) we_dat_b = 1'b1; else size_bad = 1'b1;
                RA_IRQ:   if (!bus_wide) we_irq   = 1'b1; else size_bad = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pa_oe_q    <= '0;
            pa_do_q    <= '0;
            pb_oe_q    <= '0;
            pb_do_q    <= '0;
            irq_q      <= '0;
            err_size   <= 1'b0;
            err_irqctl <= 1'b0;
        end else begin
            pa_oe_q <= per_oe_a;
            pa_do_q <= per_do_a;
            pb_oe_q <= per_oe_b;
            pb_do_q <= per_do_b;
            if (we_irq) begin
                irq_q <= bus_wdata[15:0];
                if (bus_wdata[15:0] != 16'd0) err_irqctl <= 1'b1;
            end
            if (size_bad) err_size <= 1'b1;
        end
    end

    gpio2_port #(.W(W)) u_port_a (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(we_ctl_a), .dat_we(we_dat_a),
        .wr_ctl(bus_wdata[CW-1:0]), .wr_dat(bus_wdata[W-1:0]),
        .per_oe_q(pa_oe_q), .per_do_q(pa_do_q),
        .ctl_q(ctl_a_q), .line(pin_a), .line_next(nxt_a)
    );

    gpio2_port #(.W(W)) u_port_b (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(we_ctl_b), .dat_we(we_dat_b),
        .wr_ctl(bus_wdata[CW-1:0]), .wr_dat(bus_wdata[W-1:0]),
        .per_oe_q(pb_oe_q), .per_do_q(pb_do_q),
        .ctl_q(ctl_b_q), .line(pin_b), .line_next(nxt_b)
    );

    gpio2_notify #(.W(W), .NL(NL)) u_notify (
        .clk(clk), .rst_n(rst_n),
        .trig_a(we_ctl_a | we_dat_a), .trig_b(we_ctl_b | we_dat_b),
        .chg_a(pin_a ^ nxt_a), .chg_b(pin_b ^ nxt_b),
        .lsn_en(lsn_en), .mask_a(lsn_mask_a), .mask_b(lsn_mask_b),
        .snap_a(nxt_a), .snap_b(nxt_b),
        .pulse(ntf_pulse), .snap_a_q(ntf_pin_a), .snap_b_q(ntf_pin_b)
    );

    always_comb begin
        case (bus_addr)
            RA_CTL_A: bus_rdata = 32'(ctl_a_q);
            RA_CTL_B: bus_rdata = 32'(ctl_b_q);
            RA_DAT_A: bus_rdata = 32'(pin_a);
            RA_DAT_B: bus_rdata = 32'(pin_b);
            RA_IRQ:   bus_rdata = {16'd0, irq_q};
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio2_chk.sv
module gpio2_chk #(
    parameter int W  = 16,
    parameter int NL = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [2:0]    bus_addr,
    input logic          bus_wide,
    input logic [NL-1:0] lsn_en,
    input logic [W-1:0]  per_oe_a,
    input logic [W-1:0]  per_do_a,
    input logic [W-1:0]  pin_a,
    input logic [NL-1:0] ntf_pulse,
    input logic          err_size,
    input logic          err_irqctl
);

    logic [1:0] live;
    logic       past_ok;
    logic       bad_size;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live <= 2'd0;
        else if (live != 2'd3) live <= live + 2'd1;
    end
    assign past_ok = (live == 2'd3);

    assign bad_size = bus_wr && (((bus_addr <= 3'd1) && !bus_wide)
                   || ((bus_addr >= 3'd2) && (bus_addr <= 3'd4) && bus_wide));

    a_r5_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (ntf_pulse != '0)) |-> $past(bus_wr));

    a_r5_pulse_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((ntf_pulse & ~$past(lsn_en)) == '0));

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_irqctl |=> err_irqctl);

    a_r7_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(err_size)) |-> $past(bad_size));

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_size |=> err_size);

    a_r9_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !bus_wr && $stable(per_oe_a) && $stable(per_do_a)) |=> $stable(pin_a));

endmodule

bind gpio2_top gpio2_chk #(.W(W), .NL(NL)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wide(bus_wide), .lsn_en(lsn_en), .per_oe_a(per_oe_a),
    .per_do_a(per_do_a), .pin_a(pin_a), .ntf_pulse(ntf_pulse),
    .err_size(err_size), .err_irqctl(err_irqctl)
);

// File: tb/gpio2_top_tb.sv
module gpio2_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic        bus_wide = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] per_oe_a = '0, per_do_a = '0, per_oe_b = '0, per_do_b = '0;
    logic [3:0]  lsn_en = '0;
    logic [63:0] lsn_mask_a = '0, lsn_mask_b = '0;
    logic [15:0] pin_a, pin_b, ntf_pin_a, ntf_pin_b;
    logic [3:0]  ntf_pulse;
    logic        err_size, err_irqctl;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    gpio2_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .per_oe_a(per_oe_a), .per_do_a(per_do_a), .per_oe_b(per_oe_b),
        .per_do_b(per_do_b), .lsn_en(lsn_en), .lsn_mask_a(lsn_mask_a),
        .lsn_mask_b(lsn_mask_b), .pin_a(pin_a), .pin_b(pin_b),
        .ntf_pulse(ntf_pulse), .ntf_pin_a(ntf_pin_a), .ntf_pin_b(ntf_pin_b),
        .err_size(err_size), .err_irqctl(err_irqctl)
    );

    // reference model state
    logic [31:0] m_ctl_a = '0, m_ctl_b = '0;
    logic [15:0] m_dat_a = '0, m_dat_b = '0, m_irq = '0;
    logic [15:0] m_pao = '0, m_pad = '0, m_pbo = '0, m_pbd = '0;
    logic [3:0]  m_pulse = '0;
    logic [15:0] m_npa = '0, m_npb = '0;
    logic        m_es = 1'b0, m_ei = 1'b0;

    function automatic logic [15:0] mline(logic [31:0] c, logic [15:0] d,
                                          logic [15:0] po, logic [15:0] pd);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) begin
            logic drv, pu;
            drv = c[2*i];
            pu  = c[2*i+1];
            r[i] = (drv & d[i]) | (po[i] & pd[i]) | (~(drv | po[i]) & pu);
        end
        return r;
    endfunction

    function automatic logic [31:0] mread(logic [2:0] a);
        case (a)
            3'd0: return m_ctl_a;
            3'd1: return m_ctl_b;
            3'd2: return {16'd0, mline(m_ctl_a, m_dat_a, m_pao, m_pad)};
            3'd3: return {16'd0, mline(m_ctl_b, m_dat_b, m_pbo, m_pbd)};
            3'd4: return {16'd0, m_irq};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctl_a = '0; m_ctl_b = '0; m_dat_a = '0; m_dat_b = '0; m_irq = '0;
            m_pao = '0; m_pad = '0; m_pbo = '0; m_pbd = '0;
            m_pulse = '0; m_npa = '0; m_npb = '0; m_es = 0; m_ei = 0;
        end else begin
            logic [15:0] oa, ob, na, nb;
            logic [3:0] hits;
            logic wrong, pa, pb;
            oa = mline(m_ctl_a, m_dat_a, m_pao, m_pad);
            ob = mline(m_ctl_b, m_dat_b, m_pbo, m_pbd);
            hits = '0; pa = 0; pb = 0;
            if (bus_wr) begin
                wrong = ((bus_addr <= 3'd1) && !bus_wide) ||
                        ((bus_addr >= 3'd2) && (bus_addr <= 3'd4) && bus_wide);
                if (wrong) m_es = 1;
                else begin
                    case (bus_addr)
                        3'd0: begin m_ctl_a = bus_wdata; pa = 1; end
                        3'd1: begin m_ctl_b = bus_wdata; pb = 1; end
                        3'd2: begin m_dat_a = bus_wdata[15:0]; pa = 1; end
                        3'd3: begin m_dat_b = bus_wdata[15:0]; pb = 1; end
                        3'd4: begin m_irq = bus_wdata[15:0]; if (m_irq != 0) m_ei = 1; end
                        default: ;
                    endcase
                end
            end
            na = mline(m_ctl_a, m_dat_a, m_pao, m_pad);
            nb = mline(m_ctl_b, m_dat_b, m_pbo, m_pbd);
            for (int l = 0; l < 4; l++) begin
                if (lsn_en[l] && ((pa && ((lsn_mask_a[l*16 +: 16] & (oa ^ na)) != 0)) ||
                                  (pb && ((lsn_mask_b[l*16 +: 16] & (ob ^ nb)) != 0))))
                    hits[l] = 1;
            end
            m_pulse = hits;
            if (hits != 0) begin m_npa = na; m_npb = nb; end
            m_pao = per_oe_a; m_pad = per_do_a; m_pbo = per_oe_b; m_pbd = per_do_b;
        end
    end

    task automatic chk32(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            chk32("R1 R2 R9 pin_a", 32'(pin_a), 32'(mline(m_ctl_a, m_dat_a, m_pao, m_pad)));
            chk32("R1 R2 R9 pin_b", 32'(pin_b), 32'(mline(m_ctl_b, m_dat_b, m_pbo, m_pbd)));
            chk32("R3 bus_rdata", bus_rdata, mread(bus_addr));
            chk32("R4 R5 R10 ntf_pulse", 32'(ntf_pulse), 32'(m_pulse));
            if (m_pulse != 0) begin
                chk32("R5 ntf_pin_a", 32'(ntf_pin_a), 32'(m_npa));
                chk32("R5 ntf_pin_b", 32'(ntf_pin_b), 32'(m_npb));
            end
            chk32("R7 err_size", 32'(err_size), 32'(m_es));
            chk32("R6 err_irqctl", 32'(err_irqctl), 32'(m_ei));
        end
    end

    task automatic wr(logic [2:0] a, logic w, logic [31:0] d);
        @(negedge clk); #1;
        bus_wr = 1; bus_addr = a; bus_wide = w; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R8: reset state
        chk32("R8 reset pins", {pin_a, pin_b}, 32'd0);
        chk32("R8 reset pulse", 32'(ntf_pulse), 32'd0);
        rst_n = 1;
        idle(2);
        bus_addr = 3'd2;
        idle(1);
        chk32("R8 read after reset", bus_rdata, 32'd0);
        // R1: pull-ups on all pins of port A (odd bits), listener 0 watches bit 0
        lsn_en = 4'b0011;
        lsn_mask_a[15:0] = 16'h0001;
        lsn_mask_b[31:16] = 16'h8000;
        wr(3'd0, 1, 32'hAAAA_AAAA);
        idle(2);
        chk32("R1 pullups", 32'(pin_a), 32'h0000_FFFF);
        // R1: drive low pin 0 only (even bit 0 set, pull-up 0 cleared)
        wr(3'd2, 0, 32'h0000_0000);
        wr(3'd0, 1, 32'hAAAA_AAA9);
        idle(2);
        chk32("R1 drive pin0 low", 32'(pin_a), 32'h0000_FFFE);
        // R4: same-level write gives no pulse
        wr(3'd0, 1, 32'hAAAA_AAA9);
        // port B: output all, then data toggles
        wr(3'd1, 1, 32'h5555_5555);
        wr(3'd3, 0, 32'h0000_8000);
        wr(3'd3, 0, 32'h0000_0000);
        // R10: back-to-back writes
        @(negedge clk); #1;
        bus_wr = 1; bus_addr = 3'd3; bus_wide = 0; bus_wdata = 32'h8000;
        @(negedge clk); #1;
        bus_wdata = 32'h0000;
        @(negedge clk); #1;
        bus_wr = 0;
        idle(3);
        // R4: peripheral changes in same cycle as write, and afterwards alone
        @(negedge clk); #1;
        per_oe_a = 16'h0001; per_do_a = 16'h0001;
        bus_wr = 1; bus_addr = 3'd2; bus_wide = 0; bus_wdata = 32'h0;
        @(negedge clk); #1;
        bus_wr = 0;
        idle(3);
        per_oe_a = 16'h0000;
        idle(3);
        // R7: wrong size writes
        wr(3'd0, 0, 32'hFFFF_FFFF);
        wr(3'd2, 1, 32'hFFFF_FFFF);
        wr(3'd5, 1, 32'h1234_5678);
        bus_addr = 3'd0;
        idle(1);
        chk32("R7 ctl unchanged", bus_rdata, 32'hAAAA_AAA9);
        // R6: zero then nonzero
        wr(3'd4, 0, 32'h0);
        idle(1);
        chk32("R6 zero keeps flag low", 32'(err_irqctl), 32'd0);
        wr(3'd4, 0, 32'h0004);
        idle(1);
        chk32("R6 flag set", 32'(err_irqctl), 32'd1);
        // random traffic
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk); #1;
            bus_wr    = ($urandom % 3) == 0;
            bus_addr  = 3'($urandom % 6);
            bus_wide  = (bus_addr <= 3'd1) ? (($urandom % 8) != 0) : (($urandom % 8) == 0);
            bus_wdata = $urandom;
            if (bus_addr == 3'd4 && ($urandom % 4) != 0) bus_wdata = 32'h0;
            if (($urandom % 4) == 0) begin
                per_oe_a = 16'($urandom & $urandom); per_do_a = 16'($urandom);
                per_oe_b = 16'($urandom & $urandom); per_do_b = 16'($urandom);
            end
            if (($urandom % 16) == 0) begin
                lsn_en = 4'($urandom);
                lsn_mask_a = {$urandom & $urandom, $urandom & $urandom};
                lsn_mask_b = {$urandom & $urandom, $urandom & $urandom};
            end
        end
        bus_wr = 0;
        idle(4);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule